// File: doc/BRIEF.md
# Flag-Setting Multiply and Byte-Reverse Execution Unit

This unit is one execution slice of a small 32-bit processor datapath. It owns an eight-entry file of 32-bit registers and four condition flags: negative, zero, carry and overflow. It carries out one of three operations on that state. The first is a multiply that keeps only the low half of the product. The other two are byte-order reversals, one across the whole word and one inside each 16-bit half. Commands arrive on a command interface as an opcode plus three register indices.

The multiply runs on a shift-and-add engine that takes one multiplier bit per clock. It reports busy while it runs and gives a one-cycle done pulse when the product is written back. The reversals finish in the cycle they are accepted.

A write port for the register file and a write port for the flags let neighbouring units put results into the shared state. A combinational read port shows any register. A command that breaks an operand rule is rejected with a one-cycle error pulse and changes nothing.

Top module: `mrv_unit`

## Requirements
- R1: A multiply command (opcode 0) writes the low 32 bits of the unsigned product of register `cmd_rn` and register `cmd_rm` into register `cmd_rd`.
- R2: The multiply result equals the low 32 bits of the two's-complement product when the operands are read as signed values.
- R3: When a multiply completes, flag_n takes bit 31 of the written result, and flag_z is 1 exactly when that 32-bit result is zero.
- R4: A multiply leaves flag_c and flag_v unchanged.
- R5: A multiply command with `cmd_rd` different from `cmd_rm` is rejected. `err` is high for exactly the one cycle after acceptance, no register is written, and the engine does not start.
- R6: Opcode 1 writes register `cmd_rn` with its four bytes in reverse order into `cmd_rd`, so byte 0 moves to byte 3 and byte 1 moves to byte 2.
- R7: Opcode 2 writes register `cmd_rn` into `cmd_rd` with the two bytes inside each 16-bit half swapped, and each half stays in place.
- R8: `busy` rises on the clock edge that accepts a multiply and stays high. `done` pulses for one cycle, and the result is readable, right after the 32nd edge following acceptance. `busy` is low in that same cycle.
- R9: While `busy` is high, every command is ignored: no write, no error and no flag change.
- R10: Byte-reverse operations take effect on the accepting edge and leave all four flags unchanged.
- R11: A synchronous active-high `rst` clears all registers, all flags, `busy`, `done` and `err`. It also aborts a multiply in progress.
- R12: Opcode 3 is illegal. It raises `err` for one cycle and writes nothing.
- R13: The external register write applies on the edge where it is presented. If it targets the multiply destination on the completion edge, the product wins. The flag write port `flag_wdata` is ordered {N,Z,C,V}. On a completion edge, N and Z come from the product and C and V come from the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Opcode: 0 multiply, 1 word reverse, 2 halfword reverse, 3 illegal |
| cmd_rd | input | 3 | Destination register index |
| cmd_rn | input | 3 | First source register index |
| cmd_rm | input | 3 | Second source register index |
| wr_en | input | 1 | External register write strobe |
| wr_idx | input | 3 | External write register index |
| wr_data | input | 32 | External write data |
| flag_we | input | 1 | External flag write strobe |
| flag_wdata | input | 4 | Flag values {N,Z,C,V} |
| rd_idx | input | 3 | Read port register index |
| rd_data | output | 32 | Read port data (combinational) |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle pulse on multiply writeback |
| err | output | 1 | One-cycle pulse on a rejected command |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

## Verification
Two functions can land on the same edge: the multiply writeback, and writes from the external register and flag ports. The bench starts a multiply and counts 31 edges after acceptance. It then presents a conflicting register write and a full flag write, so both arrive on the completion edge. Once to the destination register and once to an unrelated register, it checks the following. The product must beat the port on the destination. The unrelated register must take the port value. N and Z must follow the product, and C and V must follow the port.

// File: rtl/mrv_pkg.sv
`timescale 1ns/1ps
package mrv_pkg;

    typedef enum logic [1:0] {
        OP_MUL   = 2'd0,
        OP_REV   = 2'd1,
        OP_REV16 = 2'd2,
        OP_BAD   = 2'd3
    } op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

endpackage

// File: rtl/mrv_byteswap.sv
`timescale 1ns/1ps
module mrv_byteswap #(
    parameter int W = 32
) (
    input  logic         half_mode,
    input  logic [W-1:0] data_i,
    output logic [W-1:0] data_o
);
    localparam int NB = W / 8;
    localparam int NH = W / 16;

    logic [W-1:0] full_sw;
    logic [W-1:0] half_sw;

    // whole-word reversal: byte i takes byte NB-1-i
    for (genvar i = 0; i < NB; i++) begin : g_full
        assign full_sw[8*i +: 8] = data_i[8*(NB-1-i) +: 8];
    end

    // per-halfword swap: the two bytes of each half trade places
    for (genvar h = 0; h < NH; h++) begin : g_half
        for (genvar j = 0; j < 2; j++) begin : g_byte
            assign half_sw[16*h + 8*j +: 8] = data_i[16*h + 8*(1-j) +: 8];
        end
    end

    assign data_o = half_mode ? half_sw : full_sw;

endmodule

// File: rtl/mrv_mul_engine.sv
`timescale 1ns/1ps
module mrv_mul_engine #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] mcand_i,
    input  logic [W-1:0] mplier_i,
    output logic         busy,
    output logic         last,
    output logic [W-1:0] result
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST_STEP = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
        logic [W-1:0]  mcand;
        logic [W-1:0]  mplier;
        logic [W-1:0]  acc;
    } eng_t;

    eng_t         s_d, s_q;
    logic [W-1:0] addend;
    logic [W-1:0] sum;

    always_comb begin
        s_d    = s_q;
        addend = s_q.mplier[0] ? s_q.mcand : '0;
        sum    = s_q.acc + addend;
        if (s_q.busy) begin
            s_d.acc    = sum;
            s_d.mcand  = {s_q.mcand[W-2:0], 1'b0};
            s_d.mplier = {1'b0, s_q.mplier[W-1:1]};
            s_d.cnt    = s_q.cnt + 1'b1;
            if (s_q.cnt == LAST_STEP) begin
                s_d.busy = 1'b0;
            end
        end else if (start) begin
            s_d.busy   = 1'b1;
            s_d.cnt    = '0;
            s_d.mcand  = mcand_i;
            s_d.mplier = mplier_i;
            s_d.acc    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign busy   = s_q.busy;
    assign last   = s_q.busy && (s_q.cnt == LAST_STEP);
    assign result = sum;

    p_step_zero_at_start_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(s_q.busy) |-> (s_q.cnt == '0));

    p_busy_holds_r8: assert property (@(posedge clk) disable iff (rst)
        (s_q.busy && s_q.cnt != LAST_STEP) |=> s_q.busy);

    p_idle_after_last_r8: assert property (@(posedge clk) disable iff (rst)
        last |=> !s_q.busy);

endmodule

// File: rtl/mrv_unit.sv
`timescale 1ns/1ps
module mrv_unit
    import mrv_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cmd_valid,
    input  logic [1:0]               cmd_op,
    input  logic [$clog2(NREG)-1:0]  cmd_rd,
    input  logic [$clog2(NREG)-1:0]  cmd_rn,
    input  logic [$clog2(NREG)-1:0]  cmd_rm,
    input  logic                     wr_en,
    input  logic [$clog2(NREG)-1:0]  wr_idx,
    input  logic [XLEN-1:0]          wr_data,
    input  logic                     flag_we,
    input  logic [3:0]               flag_wdata,
    input  logic [$clog2(NREG)-1:0]  rd_idx,
    output logic [XLEN-1:0]          rd_data,
    output logic                     busy,
    output logic                     done,
    output logic                     err,
    output logic                     flag_n,
    output logic                     flag_z,
    output logic                     flag_c,
    output logic                     flag_v
);
    localparam int IDXW = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] regs;
        flags_t                    flags;
        logic [IDXW-1:0]           dst;
        logic                      done;
        logic                      err;
    } unit_t;

    unit_t           st_d, st_q;
    op_e             op;
    logic            accept;
    logic            mul_go;
    logic            rev_acc;
    logic            eng_busy;
    logic            eng_last;
    logic [XLEN-1:0] eng_result;
    logic [XLEN-1:0] swap_out;

    assign op      = op_e'(cmd_op);
    assign accept  = cmd_valid && !eng_busy;
    assign mul_go  = accept && (op == OP_MUL) && (cmd_rd == cmd_rm);
    assign rev_acc = accept && ((op == OP_REV) || (op == OP_REV16));

    mrv_mul_engine #(.W(XLEN)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (mul_go),
        .mcand_i  (st_q.regs[cmd_rn]),
        .mplier_i (st_q.regs[cmd_rm]),
        .busy     (eng_busy),
        .last     (eng_last),
        .result   (eng_result)
    );

    mrv_byteswap #(.W(XLEN)) u_swap (
        .half_mode (op == OP_REV16),
        .data_i    (st_q.regs[cmd_rn]),
        .data_o    (swap_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;

        // neighbouring-unit writes have lowest priority
        if (wr_en)   st_d.regs[wr_idx] = wr_data;
        if (flag_we) st_d.flags        = flags_t'(flag_wdata);

        if (accept) begin
            unique case (op)
                OP_MUL: begin
                    if (cmd_rd != cmd_rm) st_d.err = 1'b1;
                    else                  st_d.dst = cmd_rd;
                end
                OP_REV, OP_REV16: st_d.regs[cmd_rd] = swap_out;
                default:          st_d.err = 1'b1;
            endcase
        end

        // multiply writeback wins over the external ports
        if (eng_last) begin
            st_d.regs[st_q.dst] = eng_result;
            st_d.flags.n        = eng_result[XLEN-1];
            st_d.flags.z        = (eng_result == '0);
            st_d.done           = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rd_data = st_q.regs[rd_idx];
    assign busy    = eng_busy;
    assign done    = st_q.done;
    assign err     = st_q.err;
    assign flag_n  = st_q.flags.n;
    assign flag_z  = st_q.flags.z;
    assign flag_c  = st_q.flags.c;
    assign flag_v  = st_q.flags.v;

    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    p_err_no_start_r5: assert property (@(posedge clk) disable iff (rst)
        err |-> !busy);

    p_nz_track_r3: assert property (@(posedge clk) disable iff (rst)
        done |-> (flag_z == (st_q.regs[st_q.dst] == '0))
              && (flag_n == st_q.regs[st_q.dst][XLEN-1]));

    p_cv_kept_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(flag_we)) |-> ($stable(flag_c) && $stable(flag_v)));

    p_rev_flags_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(rev_acc) && !$past(flag_we) && !$past(rst))
            |-> $stable(st_q.flags));

endmodule

// File: tb/test_mrv_unit.sv
`timescale 1ns/1ps
module test_mrv_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_rd = '0, cmd_rn = '0, cmd_rm = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        flag_we = 1'b0;
    logic [3:0]  flag_wdata = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic        busy, done, err, flag_n, flag_z, flag_c, flag_v;

    int cmp = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    mrv_unit i_mrv_unit (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_rd(cmd_rd), .cmd_rn(cmd_rn), .cmd_rm(cmd_rm),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .flag_we(flag_we), .flag_wdata(flag_wdata),
        .rd_idx(rd_idx), .rd_data(rd_data), .busy(busy), .done(done), .err(err),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic tick;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        cmp++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wreg(input logic [2:0] i, input logic [31:0] v);
        wr_en = 1'b1; wr_idx = i; wr_data = v;
        tick;
        wr_en = 1'b0;
    endtask

    task automatic wflags(input logic [3:0] f);
        flag_we = 1'b1; flag_wdata = f;
        tick;
        flag_we = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] i, output logic [31:0] v);
        rd_idx = i;
        #0.5;
        v = rd_data;
    endtask

    function automatic logic [3:0] flags_now();
        return {flag_n, flag_z, flag_c, flag_v};
    endfunction

    task automatic issue(input logic [1:0] op, input logic [2:0] rd,
                         input logic [2:0] rn, input logic [2:0] rm);
        cmd_valid = 1'b1; cmd_op = op; cmd_rd = rd; cmd_rn = rn; cmd_rm = rm;
        tick;
        cmd_valid = 1'b0;
    endtask

    task automatic run_mul(input logic [2:0] rd, input logic [2:0] rn, output int lat);
        issue(2'd0, rd, rn, rd);
        chk("R8 busy after accept", 32'(busy), 32'd1);
        lat = 0;
        while (!done && lat < 40) begin
            tick;
            lat++;
        end
    endtask

    function automatic logic [31:0] pick(int i, int s);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            default: return (32'(i) * 32'h9E37_79B9) ^ (32'(s) * 32'h85EB_CA6B) ^ (32'(i) << s);
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, e, r;
        logic [63:0] p;
        int lat;

        // R11: reset clears everything, including earlier writes
        tick; tick;
        rst = 1'b0;
        for (int i = 0; i < 8; i++) wreg(3'(i), 32'h1111_1111 * 32'(i + 1));
        wflags(4'hF);
        rst = 1'b1;
        tick;
        rst = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rreg(3'(i), v);
            chk("R11 reg cleared", v, 32'd0);
        end
        chk("R11 flags cleared", 32'(flags_now()), 32'd0);
        chk("R11 busy/done/err cleared", {29'd0, busy, done, err}, 32'd0);

        // R1 R3 R4 R8: unsigned multiply sweep
        for (int i = 0; i < 40; i++) begin
            logic [2:0] rn, rm;
            logic [31:0] a, b;
            logic [3:0] pre;
            rn = 3'(i % 8);
            rm = 3'((i + 3) % 8);
            a  = pick(i, 1);
            b  = (i < 4) ? pick(3 - i, 2) : pick(i + 11, 2);
            wreg(rn, a);
            wreg(rm, b);
            pre = {2'b11, i[0], i[1]};
            wflags(pre);
            run_mul(rm, rn, lat);
            chk("R8 latency", 32'(lat), 32'd32);
            chk("R8 busy low at done", 32'(busy), 32'd0);
            p = {32'd0, a} * {32'd0, b};
            e = p[31:0];
            rreg(rm, r);
            chk("R1 product", r, e);
            chk("R3 N flag", 32'(flag_n), 32'(e[31]));
            chk("R3 Z flag", 32'(flag_z), 32'(e == 32'd0));
            chk("R4 C/V kept", {30'd0, flag_c, flag_v}, {30'd0, pre[1:0]});
            tick;
            chk("R8 done one cycle", 32'(done), 32'd0);
        end

        // R2: signed operands give the same low word
        for (int i = 0; i < 16; i++) begin
            int sa, sb;
            longint sp;
            sa = -(i * 12345 + 7);
            sb = i * 77 - 600;
            wreg(3'd1, 32'(sa));
            wreg(3'd6, 32'(sb));
            run_mul(3'd6, 3'd1, lat);
            sp = longint'(sa) * longint'(sb);
            rreg(3'd6, r);
            chk("R2 signed product", r, sp[31:0]);
        end

        // R6 R7 R10: byte-reverse sweep
        for (int i = 0; i < 64; i++) begin
            logic [3:0] pre;
            v = (32'(i) * 32'h0123_4567) ^ (32'h0F1E_2D3C << (i % 8));
            pre = 4'(i);
            wreg(3'd3, v);
            wflags(pre);
            issue(2'd1, 3'd4, 3'd3, 3'd0);
            e = ((v & 32'hFF) << 24) | ((v & 32'hFF00) << 8) |
                ((v >> 8) & 32'hFF00) | (v >> 24);
            rreg(3'd4, r);
            chk("R6 word reverse", r, e);
            issue(2'd2, 3'd3, 3'd3, 3'd0);
            e = ((v & 32'h00FF_00FF) << 8) | ((v >> 8) & 32'h00FF_00FF);
            rreg(3'd3, r);
            chk("R7 halfword reverse", r, e);
            chk("R10 flags untouched", 32'(flags_now()), 32'(pre));
        end

        // R5: destination differs from second source
        wreg(3'd3, 32'hCAFE_F00D);
        wreg(3'd1, 32'd5);
        wreg(3'd2, 32'd7);
        issue(2'd0, 3'd3, 3'd1, 3'd2);
        chk("R5 err pulse", 32'(err), 32'd1);
        chk("R5 engine idle", 32'(busy), 32'd0);
        tick;
        chk("R5 err one cycle", 32'(err), 32'd0);
        for (int k = 0; k < 34; k++) begin
            if (done) chk("R5 no done", 32'(done), 32'd0);
            tick;
        end
        rreg(3'd3, r);
        chk("R5 no write", r, 32'hCAFE_F00D);

        // R12: illegal opcode
        issue(2'd3, 3'd3, 3'd1, 3'd2);
        chk("R12 err pulse", 32'(err), 32'd1);
        tick;
        rreg(3'd3, r);
        chk("R12 no write", r, 32'hCAFE_F00D);

        // R9: commands during busy are ignored
        wreg(3'd5, 32'h1111_1111);
        wreg(3'd1, 32'd3);
        wreg(3'd2, 32'd5);
        wflags(4'b0000);
        issue(2'd0, 3'd2, 3'd1, 3'd2);
        tick;
        issue(2'd1, 3'd5, 3'd1, 3'd0);
        issue(2'd0, 3'd6, 3'd1, 3'd7);
        chk("R9 no err while busy", 32'(err), 32'd0);
        issue(2'd3, 3'd5, 3'd1, 3'd0);
        chk("R9 illegal ignored", 32'(err), 32'd0);
        lat = 0;
        while (!done && lat < 40) begin tick; lat++; end
        rreg(3'd5, r);
        chk("R9 reg untouched", r, 32'h1111_1111);
        rreg(3'd2, r);
        chk("R9 product still right", r, 32'd15);

        // R13: external write to destination on completion edge
        wreg(3'd1, 32'h0001_0000);
        wreg(3'd2, 32'h0001_0000);
        wflags(4'b0000);
        issue(2'd0, 3'd2, 3'd1, 3'd2);
        for (int k = 0; k < 31; k++) tick;
        wr_en = 1'b1; wr_idx = 3'd2; wr_data = 32'hDEAD_BEEF;
        flag_we = 1'b1; flag_wdata = 4'b1011;
        tick;
        wr_en = 1'b0; flag_we = 1'b0;
        chk("R13 done on collision edge", 32'(done), 32'd1);
        rreg(3'd2, r);
        chk("R13 product wins", r, 32'd0);
        chk("R13 flags merge", 32'(flags_now()), 32'b0111);

        // R13: external write to another register on completion edge
        wreg(3'd1, 32'hFFFF_FFFF);
        wreg(3'd2, 32'd2);
        issue(2'd0, 3'd2, 3'd1, 3'd2);
        for (int k = 0; k < 31; k++) tick;
        wr_en = 1'b1; wr_idx = 3'd4; wr_data = 32'h1234_5678;
        flag_we = 1'b1; flag_wdata = 4'b0100;
        tick;
        wr_en = 1'b0; flag_we = 1'b0;
        rreg(3'd2, r);
        chk("R13 product", r, 32'hFFFF_FFFE);
        rreg(3'd4, r);
        chk("R13 other reg written", r, 32'h1234_5678);
        chk("R13 flags merge 2", 32'(flags_now()), 32'b1000);

        // R11: reset aborts a multiply
        wreg(3'd1, 32'd9);
        wreg(3'd2, 32'd9);
        issue(2'd0, 3'd2, 3'd1, 3'd2);
        for (int k = 0; k < 5; k++) tick;
        rst = 1'b1;
        tick;
        rst = 1'b0;
        chk("R11 busy cleared mid-run", 32'(busy), 32'd0);
        lat = 0;
        for (int k = 0; k < 40; k++) begin
            if (done) lat++;
            tick;
        end
        chk("R11 no late done", 32'(lat), 32'd0);
        rreg(3'd2, r);
        chk("R11 dest cleared", r, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp, bad);
        $finish;
    end

endmodule